// File: doc/BRIEF.md
# Horizon-Based Flow Control Time Generator

This block sits beside the channel scheduler of one output link in a burst switch stage. The scheduler keeps a horizon for every data channel: the latest time at which that channel is booked. A channel is free for a new burst at any time at or after its horizon. The block keeps its own copy of these horizons. From them it works out the earliest future time at which a chosen number of channels will be free at once. That time is offered to the upstream stages as the moment from which they may send new bursts. Upstream senders must not start a burst before it.

The chosen number of channels (the threshold) is normally the number of upstream neighbours, but it is a configurable input. The scheduler writes one horizon per cycle. Every write starts a new computation. The computation is a sequential selection that visits one candidate channel per cycle. For each candidate it counts how many horizons are at or below the candidate's value, and it keeps the smallest candidate whose count reaches the threshold. That value is the k-th smallest horizon. It is then raised to the current time if it lies in the past. The block pulses a strobe when the advertised time changes. The transport that carries the value upstream is outside this block.

Top module: `hzfc_gen`

## Requirements
- R1: After reset every stored horizon is 0, `adv_time` is 0 and `adv_strobe` is 0.
- R2: A write (`hz_wr`=1) stores `hz_wr_val` as the horizon of channel `hz_wr_ch` and starts a computation. The result appears on `adv_time` after the 8th rising edge following the edge that accepts the write. Before that, `adv_time` holds its old value.
- R3: For a threshold k with 1 <= k <= 8, the result is the k-th smallest of the 8 stored horizons. Equal values are counted once for each channel that holds them.
- R4: A threshold of 0 gives a result equal to `now_time` at the completing edge.
- R5: A threshold greater than 8 gives the all-ones value (0xFFFF at the default 16-bit width), meaning "never".
- R6: A result below `now_time` at the completing edge is raised to `now_time`. The advertised time is never earlier than the current time when it is produced.
- R7: `adv_strobe` is high for exactly the one cycle in which `adv_time` takes a new, different value. It stays low when a computation ends with the old value, and `adv_time` changes at no other time.
- R8: A write that arrives while a computation is running restarts the computation. No result is produced for the interrupted run. The single result comes 8 edges after the last write and reflects every write.
- R9: The threshold is sampled on the edge that accepts a write. A change of `thresh` without a write has no effect on `adv_time` or `adv_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| now_time | input | TIME_W (16) | Current local time |
| hz_wr | input | 1 | Horizon write enable from the channel scheduler |
| hz_wr_ch | input | CH_W (3) | Channel whose horizon is written |
| hz_wr_val | input | TIME_W (16) | New horizon value |
| thresh | input | THR_W (5) | Number of channels that must be free at once |
| adv_time | output | TIME_W (16) | Advertised earliest send time for upstream stages |
| adv_strobe | output | 1 | One-cycle pulse when `adv_time` changes |

## Verification
The bound checker watches, on every cycle, that the strobe and changes of `adv_time` occur together and only at the end of a scan. It also checks that a finished result is never below the current time, and that thresholds of zero or above the channel count give the current time or the never value. A write is seen never to be followed directly by a completion. Whether the value is truly the k-th smallest horizon, including ties, the 8-edge latency, restarts by later writes and the capture of the threshold only at write time can only be shown by the bench's scenarios. The bench compares these against a sorting model of the horizons.

// File: rtl/hzfc_pkg.sv
package hzfc_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_st_e;
endpackage

// File: rtl/hzfc_hz_bank.sv
module hzfc_hz_bank #(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [TIME_W-1:0]        wr_val,
  output logic [NUM_CH*TIME_W-1:0] hz_flat
);
  logic [TIME_W-1:0] hz_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hz_q[g] <= '0;
      end else if (wr_en && (wr_ch == CH_W'(g))) begin
        hz_q[g] <= wr_val;
      end
    end
    assign hz_flat[g*TIME_W +: TIME_W] = hz_q[g];
  end
endmodule

// File: rtl/hzfc_rank_count.sv
module hzfc_rank_count #(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 16,
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic [NUM_CH*TIME_W-1:0] hz_flat,
  input  logic [TIME_W-1:0]        cand,
  output logic [CNT_W-1:0]         free_cnt
);
  // Number of channels that are free at time 'at' (horizon <= at).
  function automatic logic [CNT_W-1:0] count_free(
    input logic [NUM_CH*TIME_W-1:0] hz,
    input logic [TIME_W-1:0]        at
  );
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hz[i*TIME_W +: TIME_W] <= at) n = n + CNT_W'(1);
    end
    return n;
  endfunction

  assign free_cnt = count_free(hz_flat, cand);
endmodule

// File: rtl/hzfc_scan.sv
module hzfc_scan
  import hzfc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 16,
  parameter int THR_W  = $clog2(NUM_CH + 1) + 1,
  localparam int IDX_W = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [THR_W-1:0]         thresh,
  input  logic [TIME_W-1:0]        now_time,
  input  logic [NUM_CH*TIME_W-1:0] hz_flat,
  output logic                     scan_done,
  output logic [TIME_W-1:0]        final_time,
  output logic [THR_W-1:0]         k_cur
);
  scan_st_e          st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TIME_W-1:0] best_q;
  logic [TIME_W-1:0] best_nx;
  logic [TIME_W-1:0] cand;
  logic [CNT_W-1:0]  free_cnt;
  logic              cand_ok;

  // Advertised time from the selected horizon, threshold and current time.
  function automatic logic [TIME_W-1:0] shape_time(
    input logic [TIME_W-1:0] sel,
    input logic [THR_W-1:0]  k,
    input logic [TIME_W-1:0] now
  );
    if (k == '0)  return now;
    if (sel < now) return now;
    return sel;
  endfunction

  assign cand = hz_flat[idx_q*TIME_W +: TIME_W];

  hzfc_rank_count #(.NUM_CH(NUM_CH), .TIME_W(TIME_W)) u_rank (
    .hz_flat  (hz_flat),
    .cand     (cand),
    .free_cnt (free_cnt)
  );

  assign cand_ok    = (THR_W'(free_cnt) >= k_cur);
  assign best_nx    = (cand_ok && (cand < best_q)) ? cand : best_q;
  assign scan_done  = (st_q == SCAN_RUN) && (idx_q == IDX_W'(NUM_CH - 1)) && !start;
  assign final_time = shape_time(best_nx, k_cur, now_time);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SCAN_IDLE;
      idx_q  <= '0;
      best_q <= '1;
      k_cur  <= '0;
    end else if (start) begin
      st_q   <= SCAN_RUN;
      idx_q  <= '0;
      best_q <= '1;
      k_cur  <= thresh;
    end else if (st_q == SCAN_RUN) begin
      best_q <= best_nx;
      idx_q  <= idx_q + IDX_W'(1);
      if (idx_q == IDX_W'(NUM_CH - 1)) st_q <= SCAN_IDLE;
    end
  end
endmodule

// File: rtl/hzfc_gen.sv
module hzfc_gen #(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 16,
  parameter int THR_W  = $clog2(NUM_CH + 1) + 1,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_time,
  input  logic              hz_wr,
  input  logic [CH_W-1:0]   hz_wr_ch,
  input  logic [TIME_W-1:0] hz_wr_val,
  input  logic [THR_W-1:0]  thresh,
  output logic [TIME_W-1:0] adv_time,
  output logic              adv_strobe
);
  logic [NUM_CH*TIME_W-1:0] hz_flat;
  logic                     scan_done;
  logic [TIME_W-1:0]        final_time;
  logic [THR_W-1:0]         k_cur;

  hzfc_hz_bank #(.NUM_CH(NUM_CH), .TIME_W(TIME_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (hz_wr),
    .wr_ch   (hz_wr_ch),
    .wr_val  (hz_wr_val),
    .hz_flat (hz_flat)
  );

  hzfc_scan #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .THR_W(THR_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (hz_wr),
    .thresh     (thresh),
    .now_time   (now_time),
    .hz_flat    (hz_flat),
    .scan_done  (scan_done),
    .final_time (final_time),
    .k_cur      (k_cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adv_time   <= '0;
      adv_strobe <= 1'b0;
    end else begin
      adv_strobe <= 1'b0;
      if (scan_done && (final_time != adv_time)) begin
        adv_time   <= final_time;
        adv_strobe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hzfc_gen_chk.sv
module hzfc_gen_chk #(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 16,
  parameter int THR_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TIME_W-1:0] now_time,
  input logic              hz_wr,
  input logic [TIME_W-1:0] adv_time,
  input logic              adv_strobe,
  input logic              scan_done,
  input logic [THR_W-1:0]  k_cur
);
  p_strobe_means_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_strobe |-> (adv_time != $past(adv_time)));

  p_change_has_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_time != $past(adv_time)) |-> adv_strobe);

  p_strobe_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_strobe |=> !adv_strobe);

  p_change_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_time != $past(adv_time)) |-> $past(scan_done));

  p_not_in_past_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> (adv_time >= $past(now_time)));

  p_zero_thr_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && (k_cur == '0)) |=> (adv_time == $past(now_time)));

  p_big_thr_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && (k_cur > THR_W'(NUM_CH))) |=> (adv_time == '1));

  p_write_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hz_wr |=> !scan_done);
endmodule

bind hzfc_gen hzfc_gen_chk #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .THR_W(THR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .now_time   (now_time),
  .hz_wr      (hz_wr),
  .adv_time   (adv_time),
  .adv_strobe (adv_strobe),
  .scan_done  (scan_done),
  .k_cur      (k_cur)
);

// File: tb/hzfc_gen_tb.sv
module hzfc_gen_tb;
  localparam int NUM_CH = 8;
  localparam int TIME_W = 16;
  localparam int THR_W  = 5;
  localparam int CH_W   = 3;
  localparam int NVEC   = 12;

  // Vector layout: {channel[3], horizon[16], threshold[5], now[16]}
  localparam logic [39:0] VEC [NVEC] = '{
    {3'd0, 16'd100,   5'd3, 16'd10},
    {3'd1, 16'd200,   5'd3, 16'd10},
    {3'd2, 16'd300,   5'd3, 16'd10},
    {3'd3, 16'd400,   5'd3, 16'd10},
    {3'd4, 16'd500,   5'd3, 16'd10},
    {3'd5, 16'd600,   5'd3, 16'd10},
    {3'd6, 16'd150,   5'd3, 16'd20},
    {3'd7, 16'd150,   5'd3, 16'd20},
    {3'd0, 16'd50,    5'd5, 16'd20},
    {3'd2, 16'd1000,  5'd4, 16'd400},
    {3'd1, 16'd5,     5'd8, 16'd0},
    {3'd3, 16'd65000, 5'd1, 16'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TIME_W-1:0] now_time = '0;
  logic              hz_wr = 1'b0;
  logic [CH_W-1:0]   hz_wr_ch = '0;
  logic [TIME_W-1:0] hz_wr_val = '0;
  logic [THR_W-1:0]  thresh = '0;
  logic [TIME_W-1:0] adv_time;
  logic              adv_strobe;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  logic [TIME_W-1:0] model_hz [NUM_CH];
  logic [TIME_W-1:0] prev_adv;

  always #5 clk = ~clk;

  hzfc_gen #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .THR_W(THR_W)) u_dut (
    .clk, .rst_n, .now_time, .hz_wr, .hz_wr_ch, .hz_wr_val, .thresh,
    .adv_time, .adv_strobe
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail   = n_fail + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 20000)", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bench model: sort a copy of the horizons, pick the k-th, then shape it.
  function automatic logic [TIME_W-1:0] model_time(input int k, input logic [TIME_W-1:0] now);
    logic [TIME_W-1:0] s [NUM_CH];
    logic [TIME_W-1:0] t;
    for (int i = 0; i < NUM_CH; i++) s[i] = model_hz[i];
    for (int a = 0; a < NUM_CH; a++)
      for (int b = 0; b < NUM_CH - 1 - a; b++)
        if (s[b] > s[b+1]) begin t = s[b]; s[b] = s[b+1]; s[b+1] = t; end
    if (k == 0) return now;
    if (k > NUM_CH) return '1;
    return (s[k-1] < now) ? now : s[k-1];
  endfunction

  // Drive one write at a negedge; returns at the negedge after the accepting edge.
  task automatic put(input int ch, input int val, input int thr, input int now);
    @(negedge clk);
    hz_wr = 1'b1; hz_wr_ch = CH_W'(ch); hz_wr_val = TIME_W'(val);
    thresh = THR_W'(thr); now_time = TIME_W'(now);
    model_hz[ch] = TIME_W'(val);
    @(negedge clk);
    hz_wr = 1'b0;
  endtask

  // Wait for completion and check value and strobe.
  task automatic finish_and_check(input int thr, input string tag);
    logic [TIME_W-1:0] exp;
    exp = model_time(thr, now_time);
    repeat (7) @(negedge clk);
    check(adv_time == prev_adv, {tag, " R2 value held during scan"}, adv_time, prev_adv);
    @(negedge clk);
    check(adv_time == exp, {tag, " value"}, adv_time, exp);
    check(adv_strobe == (exp != prev_adv), {tag, " R7 strobe"}, adv_strobe, exp != prev_adv);
    @(negedge clk);
    check(adv_strobe == 1'b0, {tag, " R7 strobe one cycle"}, adv_strobe, 0);
    prev_adv = adv_time;
  endtask

  initial begin
    for (int i = 0; i < NUM_CH; i++) model_hz[i] = '0;
    prev_adv = '0;
    repeat (3) @(negedge clk);
    check(adv_time == '0, "R1 reset adv_time", adv_time, 0);
    check(adv_strobe == 1'b0, "R1 reset strobe", adv_strobe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(adv_time == '0, "R1 after release", adv_time, 0);

    // Table of writes: R3 k-th selection with ties, R6 clamping.
    for (int v = 0; v < NVEC; v++) begin
      put(int'(VEC[v][39:37]), int'(VEC[v][36:21]), int'(VEC[v][20:16]), int'(VEC[v][15:0]));
      finish_and_check(int'(VEC[v][20:16]), $sformatf("R3/R6 vec%0d", v));
    end

    // R4: threshold zero gives current time.
    put(4, 700, 0, 777);
    finish_and_check(0, "R4 zero threshold");

    // R5: threshold above channel count gives never.
    put(4, 700, 9, 777);
    finish_and_check(9, "R5 never value");

    // R3: full threshold picks the largest horizon.
    put(6, 3000, 8, 0);
    finish_and_check(8, "R3 k=8");

    // R9: threshold change without a write has no effect.
    @(negedge clk);
    thresh = 5'd1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 11) begin
        check(adv_time == prev_adv, "R9 thresh alone value", adv_time, prev_adv);
        check(adv_strobe == 1'b0, "R9 thresh alone strobe", adv_strobe, 0);
      end
    end

    // R9: threshold sampled at the write edge, later change ignored.
    put(7, 2500, 2, 0);
    thresh = 5'd8;
    finish_and_check(2, "R9 sampled threshold");

    // R8: second write during a scan restarts it.
    put(5, 4000, 8, 0);
    repeat (2) @(negedge clk);
    put(6, 9000, 8, 0);
    finish_and_check(8, "R8 restart");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule